// File: doc/BRIEF.md
# Random-Walk Sampler with History

This block produces a slowly wandering pseudo-random value and keeps a record of its recent past for a display to draw. A 32-bit shift register with linear feedback runs on every clock and sends out one bit per cycle. The last four of those bits form a small random step.

A prescaler sets how often a sample is taken. On each sample the step, biased to zero mean, moves an 8-bit running total. The total as it stood before the move is written into a 128-byte circular history. The history write position is exposed, so a display can add it to its column number and get a scrolling picture that wraps around with no extra logic. A combinational read port returns any history byte by column.

Top module: `rw_history`

## Requirements
- R1: The bit source is a 32-bit register that resets to 1. Each clock it shifts toward the MSB, and the new LSB is the XOR of the register bits selected by mask 0x80000412. `rnd_bit_o` is a flop that each clock takes the register MSB as it was before the shift, and it resets to 0.
- R2: A 4-bit window resets to 0. Each clock it shifts up by one with `rnd_bit_o` entering at bit 0, so bit 3 holds the oldest bit.
- R3: A sample event happens on a clock where the prescale counter equals `DELAY`, and the counter then returns to 0. Events are therefore exactly `DELAY`+1 clocks apart. The default `DELAY` is 900000.
- R4: On a sample event with a window value w other than 15, `acc_o` becomes (acc_o + w - 7) mod 256. Between events `acc_o` holds.
- R5: On a sample event with a window value of 15, `acc_o` keeps its value.
- R6: On every sample event, the value of `acc_o` before the update is written to history entry `idx_o`. `idx_o` then increments and wraps from 127 to 0, and it changes at no other time.
- R7: `rd_data_o` shows, in the same cycle, the history byte at column `rd_col_i`.
- R8: Asserting `rst_ni` low (asynchronous) sets `acc_o` to 127, `idx_o` to 0, every history byte to 0, and the counter and window to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rd_col_i | input | 7 | History column to read |
| rd_data_o | output | 8 | History byte at `rd_col_i` (combinational) |
| acc_o | output | 8 | Running total |
| idx_o | output | 7 | Next history write position / scroll offset |
| rnd_bit_o | output | 1 | Registered random bit |

## Verification
`rnd_bit_o` changes one clock after the register bit it copies. The window sees that bit one clock later still. A sample event updates `acc_o` and `idx_o` at the edge where the counter matches, and the history byte at the old index becomes visible at that same edge. The bench runs its own model of the register, window, counter and total, clocked on the same edges, and compares all outputs at every falling edge, so each result is checked half a period after the edge that produces it. The read port has no register, so it is checked 1 ns after the column is driven. Event spacing is measured by counting clocks between changes of `idx_o`.

// File: rtl/rw_pkg.sv
package rw_pkg;
  localparam int unsigned LFSR_W    = 32;
  localparam logic [31:0] LFSR_SEED = 32'h0000_0001;
  localparam logic [31:0] LFSR_TAPS = 32'h8000_0412;
  localparam int unsigned STEP_W    = 4;
  localparam int unsigned ACC_W     = 8;
  localparam logic [7:0]  ACC_INIT  = 8'd127;
  localparam logic [7:0]  STEP_BIAS = 8'd7;
  localparam logic [3:0]  STEP_SKIP = 4'd15;

  typedef logic [ACC_W-1:0]  acc_t;
  typedef logic [STEP_W-1:0] step_t;
endpackage

// File: rtl/rw_lfsr.sv
module rw_lfsr
  import rw_pkg::*;
#(
  parameter int unsigned W    = LFSR_W,
  parameter logic [W-1:0] SEED = LFSR_SEED,
  parameter logic [W-1:0] TAPS = LFSR_TAPS
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic bit_o
);
  logic [W-1:0] sr_q;
  logic [W-1:0] fb_chain;

  // XOR chain over masked bits
  for (genvar i = 0; i < W; i++) begin : g_fb
    if (i == 0) begin : g_first
      assign fb_chain[i] = sr_q[i] & TAPS[i];
    end else begin : g_rest
      assign fb_chain[i] = fb_chain[i-1] ^ (sr_q[i] & TAPS[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= SEED;
      bit_o <= 1'b0;
    end else begin
      sr_q  <= {sr_q[W-2:0], fb_chain[W-1]};
      bit_o <= sr_q[W-1];
    end
  end

  // R1
  lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) sr_q != '0);
endmodule

// File: rtl/rw_walk.sv
module rw_walk
  import rw_pkg::*;
#(
  parameter int unsigned DELAY = 900000,
  localparam int unsigned CNT_W = (DELAY < 1) ? 1 : $clog2(DELAY + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  output logic wr_en_o,
  output acc_t wr_data_o,
  output acc_t acc_o
);
  logic [CNT_W-1:0] cnt_q;
  step_t            win_q;
  acc_t             acc_q;
  logic             evt;

  assign evt       = (cnt_q == CNT_W'(DELAY));
  assign wr_en_o   = evt;
  assign wr_data_o = acc_q;
  assign acc_o     = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      win_q <= '0;
      acc_q <= ACC_INIT;
    end else begin
      win_q <= {win_q[STEP_W-2:0], bit_i};
      if (evt) begin
        cnt_q <= '0;
        // code 15 dropped to balance the step around zero
        if (win_q != STEP_SKIP)
          acc_q <= acc_t'(acc_q + acc_t'(win_q) - STEP_BIAS);
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R4
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt |=> $stable(acc_o));
  // R5
  skip_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt && win_q == STEP_SKIP) |=> $stable(acc_o));
  // R3
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt |=> cnt_q == '0);
endmodule

// File: rtl/rw_ring.sv
module rw_ring
  import rw_pkg::*;
#(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  acc_t             wr_data_i,
  input  logic [IDX_W-1:0] rd_addr_i,
  output acc_t             rd_data_o,
  output logic [IDX_W-1:0] wr_ptr_o
);
  acc_t             mem_q [DEPTH];
  logic [IDX_W-1:0] ptr_q;

  assign wr_ptr_o  = ptr_q;
  assign rd_data_o = mem_q[rd_addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[ptr_q] <= wr_data_i;
      ptr_q        <= ptr_q + 1'b1;  // power-of-two depth wraps for free
    end
  end

  // R6
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(wr_ptr_o));
  // R6
  ring_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mem_q[$past(ptr_q)] == $past(wr_data_i));
endmodule

// File: rtl/rw_history.sv
module rw_history
  import rw_pkg::*;
#(
  parameter int unsigned DELAY = 900000,
  parameter int unsigned DEPTH = 128,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_col_i,
  output logic [ACC_W-1:0] rd_data_o,
  output logic [ACC_W-1:0] acc_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             rnd_bit_o
);
  logic rnd_bit;
  logic wr_en;
  acc_t wr_data;

  rw_lfsr u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bit_o  (rnd_bit)
  );

  rw_walk #(.DELAY(DELAY)) u_walk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_i     (rnd_bit),
    .wr_en_o   (wr_en),
    .wr_data_o (wr_data),
    .acc_o     (acc_o)
  );

  rw_ring #(.DEPTH(DEPTH)) u_ring (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_col_i),
    .rd_data_o (rd_data_o),
    .wr_ptr_o  (idx_o)
  );

  assign rnd_bit_o = rnd_bit;
endmodule

// File: tb/rw_history_tb_top.sv
module rw_history_tb_top;
  localparam int unsigned DLY = 5;
  localparam logic [31:0] TAPS = 32'h8000_0412;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [6:0] rd_col_i = '0;
  logic [7:0] rd_data_o, acc_o;
  logic [6:0] idx_o;
  logic       rnd_bit_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  rw_history #(.DELAY(DLY), .DEPTH(128)) dut_i (
    .clk_i, .rst_ni, .rd_col_i, .rd_data_o, .acc_o, .idx_o, .rnd_bit_o
  );

  always #2.5 clk_i = ~clk_i;

  // reference model built from the requirements
  logic [31:0] m_sr;
  logic        m_bit;
  logic [3:0]  m_win;
  int          m_cnt;
  logic [7:0]  m_acc;
  logic [6:0]  m_idx;
  logic [7:0]  m_mem [128];
  bit          m_skip_evt;
  int          skip_seen;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_sr <= 32'd1; m_bit <= 1'b0; m_win <= '0; m_cnt <= 0;
      m_acc <= 8'd127; m_idx <= '0; m_skip_evt <= 1'b0;
      for (int i = 0; i < 128; i++) m_mem[i] <= '0;
    end else begin
      m_sr  <= {m_sr[30:0], ^(m_sr & TAPS)};
      m_bit <= m_sr[31];
      m_win <= {m_win[2:0], m_bit};
      m_skip_evt <= (m_cnt == DLY) && (m_win == 4'd15);
      if (m_cnt == DLY) begin
        m_cnt <= 0;
        if (m_win != 4'd15) m_acc <= m_acc + {4'd0, m_win} - 8'd7;
        m_mem[m_idx] <= m_acc;
        m_idx <= m_idx + 7'd1;
      end else begin
        m_cnt <= m_cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_history(input string req);
    for (int c = 0; c < 128; c++) begin
      @(negedge clk_i);
      rd_col_i = 7'(c);
      #1;
      chk(rd_data_o == m_mem[c], req, rd_data_o, m_mem[c]);
    end
  endtask

  // R8: reset state
  task automatic t_reset;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(acc_o == 8'd127, "R8 acc", acc_o, 127);
    chk(idx_o == 7'd0, "R8 idx", idx_o, 0);
    chk(rnd_bit_o == 1'b0, "R8 bit", rnd_bit_o, 0);
    for (int c = 0; c < 128; c++) begin
      rd_col_i = 7'(c);
      #0.1;
      chk(rd_data_o == 8'd0, "R8 history", rd_data_o, 0);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  // R1/R2/R4/R5/R6: cycle-by-cycle comparison with the model
  task automatic t_walk(input int cycles);
    logic [7:0] prev_acc;
    prev_acc = acc_o;
    for (int n = 0; n < cycles; n++) begin
      @(negedge clk_i);
      chk(rnd_bit_o == m_bit, "R1 rnd_bit", rnd_bit_o, m_bit);
      chk(acc_o == m_acc, "R2/R4 acc", acc_o, m_acc);
      chk(idx_o == m_idx, "R6 idx", idx_o, m_idx);
      if (m_skip_evt) begin
        skip_seen++;
        chk(acc_o == prev_acc, "R5 skip code", acc_o, prev_acc);
      end
      prev_acc = acc_o;
    end
  endtask

  // R3: spacing of sample events
  task automatic t_spacing;
    logic [6:0] last_idx;
    int gap;
    int seen;
    gap = 0; seen = 0;
    @(negedge clk_i);
    last_idx = idx_o;
    while (seen < 6) begin
      @(negedge clk_i);
      gap++;
      if (idx_o != last_idx) begin
        if (seen > 0) chk(gap == DLY + 1, "R3 event spacing", gap, DLY + 1);
        chk(idx_o == last_idx + 7'd1, "R6 idx step", idx_o, last_idx + 7'd1);
        seen++; gap = 0; last_idx = idx_o;
      end
    end
  endtask

  // R6: index wraps 127 -> 0
  task automatic t_wrap;
    while (idx_o != 7'd127) @(negedge clk_i);
    while (idx_o == 7'd127) @(negedge clk_i);
    chk(idx_o == 7'd0, "R6 wrap", idx_o, 0);
  endtask

  initial begin
    skip_seen = 0;
    t_reset();
    t_walk(1800);
    chk(skip_seen > 0, "R5 skip code exercised", skip_seen, 1);
    t_spacing();
    t_wrap();
    check_history("R7 read port");
    t_walk(200);
    t_reset();
    check_history("R8 history after reset");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule